// File: doc/BRIEF.md
# Chainable Event Counter Unit

A small performance-monitoring block holding four 32-bit event counters: two general-purpose counters and two counters meant for bus transactions. Each counter advances by one on a single-cycle pulse on its own event input while its enable bit is set. Software sets the counters up and reads them through a plain register port. Writes take effect on the clock edge, and reads are combinational from the address.

Each general counter forms a pair with the bus counter of the same index. When a pair is chained, its bus counter no longer counts its own events. It becomes the upper 32 bits of a 64-bit count whose low half is the general counter.

Overflow raises no interrupt. It only sets a sticky per-counter flag, which software polls and clears by writing 1 to it. One global mode bit selects what an overflowing counter does next:
- **Wrap mode:** the counter wraps to zero and keeps counting.
- **Stop mode:** the counter wraps to zero and then ignores events until its flag is cleared.

Top module: `evt_ctr_unit`

## Requirements
- R1: After reset, all four counters, all overflow flags and the control register read as zero.
- R2: An unchained counter whose enable bit is set increments by exactly one on each cycle its event input is high. A counter whose enable bit is clear does not change.
- R3: When pair i is chained, the gp counter i is the low half and the bus counter i is the high half of one 64-bit count. In the same cycle that the low half rolls from all-ones to zero on an event, the high half increments. The pair counts only while the gp enable bit i is set.
- R4: While pair i is chained, the bus event input i has no effect on any counter.
- R5: An overflow (an increment from all-ones) sets that counter's sticky flag. In a chained pair, only the 64-bit overflow sets a flag, and that flag is the gp flag i. The carry from the low half into the high half sets no flag, and the bus flag i is never set while the pair is chained.
- R6: In wrap mode (control bit 6 = 1), an overflowing counter becomes zero and continues to count on later events.
- R7: In stop mode (control bit 6 = 0), an overflowing counter becomes zero and holds while its flag is set. It resumes counting on the first event after the flag is cleared.
- R8: Writing the status register clears each flag whose data bit is 1 and leaves flags written with 0 unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R9: A write to a counter's address loads the written value. If an event arrives in the same cycle, the write takes priority and the event is lost.
- R10: Register map (3-bit address, 32-bit data):
  - 0 = control: bits 0..3 enable gp0, gp1, bus0, bus1; bit 4 chains pair 0; bit 5 chains pair 1; bit 6 selects wrap mode.
  - 1 = status, with flag bits 0..3 for gp0, gp1, bus0, bus1.
  - 2 = gp0, 3 = gp1, 4 = bus0, 5 = bus1.
  - Unused control and status bits, and addresses 6 and 7, read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| evt_gp_i | input | 2 | Event pulses for gp counters 0 and 1 |
| evt_bus_i | input | 2 | Event pulses for bus counters 0 and 1 |

## Verification
The assertions assume that the event inputs are sampled once per clock, so a pulse held high for n cycles stands for n events. They also assume that configuration changes arrive only through the register port, so the chain and mode bits stay stable between writes. The bench drives every input on the falling edge and keeps events and writes single-cycle or deliberately simultaneous, so every edge sees settled values. Overflow cases are reached by loading values just below all-ones, never by counting through 2^32 events.

// File: rtl/ecu_pkg.sv
package ecu_pkg;
  localparam int unsigned CNT_W  = 32;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned NPAIR  = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_GP0  = 3'd2;
  localparam logic [ADDR_W-1:0] A_BUS0 = 3'd4;

  localparam int unsigned B_CHAIN = 4;
  localparam int unsigned B_WRAP  = 6;
  localparam int unsigned CTRL_W  = 7;
endpackage

// File: rtl/ecu_counter.sv
module ecu_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] val_o,
  output logic         full_o
);
  logic [W-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    val_q <= '0;
    else if (ld_i)  val_q <= ld_val_i;
    else if (inc_i) val_q <= val_q + 1'b1;
  end

  assign val_o  = val_q;
  assign full_o = &val_q;

  p_write_prio_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> val_o == $past(ld_val_i));
  p_step_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i && !full_o) |=> val_o == $past(val_o) + 1'b1);
  p_wrap_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i && full_o) |=> val_o == '0);
endmodule

// File: rtl/ecu_pair.sv
module ecu_pair #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_lo_i,
  input  logic         en_hi_i,
  input  logic         chain_i,
  input  logic         wrap_i,
  input  logic         evt_lo_i,
  input  logic         evt_hi_i,
  input  logic         ld_lo_i,
  input  logic         ld_hi_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         clr_lo_i,
  input  logic         clr_hi_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o,
  output logic         ovf_lo_o,
  output logic         ovf_hi_o
);
  logic lo_full, hi_full, lo_inc, hi_inc, lo_carry;
  logic ovf_lo_set, ovf_hi_set, ovf_lo_q, ovf_hi_q;

  // stop mode: a set flag blocks further events
  assign lo_inc   = en_lo_i & evt_lo_i & ~(~wrap_i & ovf_lo_q) & ~ld_lo_i;
  assign lo_carry = lo_inc & lo_full;

  always_comb begin
    if (chain_i) begin
      hi_inc     = lo_carry & ~ld_hi_i;
      ovf_lo_set = lo_carry & hi_full & ~ld_hi_i;
      ovf_hi_set = 1'b0;
    end else begin
      hi_inc     = en_hi_i & evt_hi_i & ~(~wrap_i & ovf_hi_q) & ~ld_hi_i;
      ovf_lo_set = lo_carry;
      ovf_hi_set = hi_inc & hi_full;
    end
  end

  ecu_counter #(.W(W)) u_lo (
    .clk_i, .rst_ni, .inc_i(lo_inc), .ld_i(ld_lo_i), .ld_val_i,
    .val_o(lo_o), .full_o(lo_full)
  );
  ecu_counter #(.W(W)) u_hi (
    .clk_i, .rst_ni, .inc_i(hi_inc), .ld_i(ld_hi_i), .ld_val_i,
    .val_o(hi_o), .full_o(hi_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_lo_q <= 1'b0;
      ovf_hi_q <= 1'b0;
    end else begin
      ovf_lo_q <= ovf_lo_set | (ovf_lo_q & ~clr_lo_i);
      ovf_hi_q <= ovf_hi_set | (ovf_hi_q & ~clr_hi_i);
    end
  end

  assign ovf_lo_o = ovf_lo_q;
  assign ovf_hi_o = ovf_hi_q;

  p_bus_evt_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain_i && !lo_carry && !ld_hi_i) |=> $stable(hi_o));
  p_chain_carry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain_i && lo_carry && !ld_hi_i && !hi_full) |=> hi_o == $past(hi_o) + 1'b1);
  p_no_bus_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain_i && !ovf_hi_q) |=> !ovf_hi_o);
  p_stop_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wrap_i && ovf_lo_q && !ld_lo_i) |=> $stable(lo_o));
  p_flag_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_lo_q && !clr_lo_i) |=> ovf_lo_o);
endmodule

// File: rtl/evt_ctr_unit.sv
module evt_ctr_unit
  import ecu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic [NPAIR-1:0]  evt_gp_i,
  input  logic [NPAIR-1:0]  evt_bus_i
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  gp_val  [NPAIR];
  logic [CNT_W-1:0]  bus_val [NPAIR];
  logic [NPAIR-1:0]  gp_ovf, bus_ovf;
  logic              wr_stat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         ctrl_q <= '0;
    else if (wr_en_i && addr_i == A_CTRL) ctrl_q <= wdata_i[CTRL_W-1:0];
  end

  assign wr_stat = wr_en_i && addr_i == A_STAT;

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    ecu_pair #(.W(CNT_W)) u_pair (
      .clk_i, .rst_ni,
      .en_lo_i (ctrl_q[i]),
      .en_hi_i (ctrl_q[NPAIR+i]),
      .chain_i (ctrl_q[B_CHAIN+i]),
      .wrap_i  (ctrl_q[B_WRAP]),
      .evt_lo_i(evt_gp_i[i]),
      .evt_hi_i(evt_bus_i[i]),
      .ld_lo_i (wr_en_i && addr_i == A_GP0 + ADDR_W'(i)),
      .ld_hi_i (wr_en_i && addr_i == A_BUS0 + ADDR_W'(i)),
      .ld_val_i(wdata_i),
      .clr_lo_i(wr_stat && wdata_i[i]),
      .clr_hi_i(wr_stat && wdata_i[NPAIR+i]),
      .lo_o    (gp_val[i]),
      .hi_o    (bus_val[i]),
      .ovf_lo_o(gp_ovf[i]),
      .ovf_hi_o(bus_ovf[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:        rdata_o[CTRL_W-1:0]  = ctrl_q;
      A_STAT:        rdata_o[2*NPAIR-1:0] = {bus_ovf, gp_ovf};
      A_GP0:         rdata_o = gp_val[0];
      A_GP0 + 3'd1:  rdata_o = gp_val[1];
      A_BUS0:        rdata_o = bus_val[0];
      A_BUS0 + 3'd1: rdata_o = bus_val[1];
      default:       rdata_o = '0;
    endcase
  end

  p_reset_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> ctrl_q == '0);
endmodule

// File: tb/sim_evt_ctr_unit.sv
`timescale 1ns/1ps
module sim_evt_ctr_unit;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [1:0]  evt_gp = 0, evt_bus = 0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  evt_ctr_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_gp_i(evt_gp), .evt_bus_i(evt_bus)
  );

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic chk(input logic [2:0] a, input logic [31:0] exp, input string req);
    addr = a; #1;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s addr %0d: got %h expected %h", req, a, rdata, exp);
    end
  endtask

  task automatic pulse(input logic [1:0] g, input logic [1:0] b, input int n);
    @(negedge clk); evt_gp = g; evt_bus = b;
    repeat (n) @(negedge clk);
    evt_gp = 0; evt_bus = 0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 8; a++) chk(3'(a), 0, "R1");
  endtask

  task automatic t_count;
    wr(0, 32'h9);  // en gp0, bus1
    pulse(2'b11, 2'b11, 5);
    chk(2, 5, "R2"); chk(3, 0, "R2"); chk(4, 0, "R2"); chk(5, 5, "R2");
    chk(0, 32'h9, "R10");
    wr(0, 0);
    pulse(2'b11, 2'b11, 3);
    chk(2, 5, "R2"); chk(5, 5, "R2");
  endtask

  task automatic t_chain;
    wr(0, 32'h55);  // en gp0, bus0, chain0, wrap
    wr(2, 32'hFFFF_FFFE); wr(4, 7);
    pulse(2'b01, 2'b01, 3);
    chk(2, 1, "R3"); chk(4, 8, "R3");
    chk(1, 0, "R5 carry sets no flag");
    pulse(2'b00, 2'b01, 4);
    chk(4, 8, "R4"); chk(2, 1, "R4");
    wr(2, 32'hFFFF_FFFF); wr(4, 32'hFFFF_FFFF);
    pulse(2'b01, 2'b00, 1);
    chk(2, 0, "R6"); chk(4, 0, "R6"); chk(1, 32'h1, "R5");
    pulse(2'b01, 2'b00, 2);
    chk(2, 2, "R6");
    wr(1, 0);
    chk(1, 32'h1, "R8 write 0");
    wr(1, 32'h1);
    chk(1, 0, "R8 clear");
  endtask

  task automatic t_wrap;
    wr(0, 32'h42);  // en gp1, wrap
    wr(3, 32'hFFFF_FFFE);
    pulse(2'b10, 2'b00, 4);
    chk(3, 2, "R6"); chk(1, 32'h2, "R5");
    wr(1, 32'h2);
  endtask

  task automatic t_stop;
    wr(0, 32'h08);  // en bus1, stop
    wr(5, 32'hFFFF_FFFF);
    pulse(2'b00, 2'b10, 3);
    chk(5, 0, "R7"); chk(1, 32'h8, "R5");
    wr(1, 32'h8);
    chk(1, 0, "R8");
    pulse(2'b00, 2'b10, 2);
    chk(5, 2, "R7 resume");
  endtask

  task automatic t_prio;
    wr(0, 32'h1);
    @(negedge clk); wr_en = 1; addr = 2; wdata = 32'h100; evt_gp = 2'b01;
    @(negedge clk); wr_en = 0; evt_gp = 0;
    chk(2, 32'h100, "R9");
    pulse(2'b01, 2'b00, 1);
    chk(2, 32'h101, "R9");
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_count();
    t_chain();
    t_wrap();
    t_stop();
    t_prio();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule